// File: doc/BRIEF.md
# Split Instruction/Data Address Translation Cache

This block turns virtual addresses into physical addresses for a core that fetches instructions and accesses data in the same clock. It has two separate, fully associative halves, one for each stream. Every slot in a half is compared at once against the incoming virtual page number, so a mapping may sit in any slot. The lookup is combinational: the hit flag and the physical address appear in the same cycle as the request.

When a requesting side finds no matching slot, it raises a stall. The block also asks the hardware page walker for the missing mapping, naming the side and the page number. The walker answers through a refill port, and the stalled side then hits on its next lookup. A single invalidate input empties both halves.

Top module: `split_xlat_buffer`

## Requirements
- R1: After reset, every slot in both halves is empty. Any lookup misses, and a side with its request high stalls.
- R2: An address is a 20-bit page number (bits 31:12) followed by a 12-bit offset (bits 11:0). On a hit, in the same cycle, the physical address is the stored 20-bit frame in bits 31:12 and the unchanged offset in bits 11:0. On a miss the physical address is zero.
- R3: The two halves are independent. A mapping loaded into one half is not visible in the other, and both halves translate in the same cycle.
- R4: A side stalls exactly when its request is high and it misses. A stalled side raises walk_req, with walk_vpn set to its page number and walk_side giving the side (0 = instruction, 1 = data).
- R5: A side whose request is low neither stalls nor causes a walk request, even when it would miss.
- R6: When both sides stall in the same cycle, the walk request names the instruction side and its page number. Once the instruction side hits, the walk request names the data side.
- R7: A refill (fill_valid high, fill_side choosing the half) is written on the next clock into the lowest-numbered empty slot. A half keeps 16 distinct mappings, and all of them hit.
- R8: A refill into a full half overwrites the slot chosen by that half's round-robin pointer. The pointer starts at slot 0 and moves to the next slot, wrapping, after each such overwrite. The first overwrite therefore evicts the oldest mapping and the second evicts the next oldest.
- R9: When inv_all is high, every slot in both halves is emptied on the next clock. A refill presented in that same cycle is dropped, and both round-robin pointers return to slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inv_all | input | 1 | Empty both halves on the next clock |
| if_req | input | 1 | Instruction-side lookup request |
| if_vaddr | input | 32 | Instruction virtual address |
| if_hit | output | 1 | Instruction-side mapping found |
| if_paddr | output | 32 | Instruction physical address |
| if_stall | output | 1 | Instruction side is waiting for a refill |
| dt_req | input | 1 | Data-side lookup request |
| dt_vaddr | input | 32 | Data virtual address |
| dt_hit | output | 1 | Data-side mapping found |
| dt_paddr | output | 32 | Data physical address |
| dt_stall | output | 1 | Data side is waiting for a refill |
| walk_req | output | 1 | A mapping is needed from the walker |
| walk_side | output | 1 | Side that needs the mapping (0 instruction, 1 data) |
| walk_vpn | output | 20 | Page number to walk |
| fill_valid | input | 1 | Refill write enable |
| fill_side | input | 1 | Half to refill (0 instruction, 1 data) |
| fill_vpn | input | 20 | Page number of the refill |
| fill_pfn | input | 20 | Frame number of the refill |

## Verification
The single-match assertion assumes that the walker never refills a page number that is already present in the target half. The bench respects this: it loads only page numbers that currently miss, or that it has just evicted or cleared. The priority and stall properties assume that the requests and addresses stay steady while the walker works. The bench changes its inputs only on falling edges, one lookup at a time, and holds them until it has sampled the outputs.

// File: rtl/split_xlat_pkg.sv
package split_xlat_pkg;
  localparam int VA_W  = 32;
  localparam int OFF_W = 12;
  localparam int VPN_W = VA_W - OFF_W;

  typedef enum logic {SIDE_INSTR = 1'b0, SIDE_DATA = 1'b1} xlat_side_e;

  typedef struct packed {
    logic             valid;
    logic [VPN_W-1:0] tag;
    logic [VPN_W-1:0] frame;
  } xlat_slot_t;

  // Physical address from a frame and the untouched page offset
  function automatic logic [VA_W-1:0] join_addr(input logic hit,
                                                input logic [VPN_W-1:0] frame,
                                                input logic [VA_W-1:0] va);
    return hit ? {frame, va[OFF_W-1:0]} : '0;
  endfunction
endpackage

// File: rtl/xlat_half.sv
module xlat_half
  import split_xlat_pkg::*;
#(
  parameter int SLOTS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inv,
  input  logic [VPN_W-1:0] vpn_in,
  output logic             hit,
  output logic [VPN_W-1:0] frame_out,
  output logic [SLOTS-1:0] match_vec,
  input  logic             wr_en,
  input  logic [VPN_W-1:0] wr_vpn,
  input  logic [VPN_W-1:0] wr_frame
);
  localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;

  xlat_slot_t       slots [SLOTS];
  logic [SLOTS-1:0] valid_vec;
  logic [IDX_W-1:0] rr_ptr;
  logic [IDX_W-1:0] victim;
  logic             full;

  function automatic logic [IDX_W-1:0] lowest_empty(input logic [SLOTS-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = SLOTS - 1; i >= 0; i--)
      if (!v[i]) r = IDX_W'(i);
    return r;
  endfunction

  function automatic logic [IDX_W-1:0] step_ptr(input logic [IDX_W-1:0] p);
    return (p == IDX_W'(SLOTS - 1)) ? '0 : p + 1'b1;
  endfunction

  generate
    for (genvar g = 0; g < SLOTS; g++) begin : g_cmp
      assign valid_vec[g] = slots[g].valid;
      assign match_vec[g] = slots[g].valid && (slots[g].tag == vpn_in);
    end
  endgenerate

  always_comb begin
    frame_out = '0;
    for (int i = 0; i < SLOTS; i++)
      if (match_vec[i]) frame_out = frame_out | slots[i].frame;
  end

  assign hit    = |match_vec;
  assign full   = &valid_vec;
  assign victim = full ? rr_ptr : lowest_empty(valid_vec);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < SLOTS; i++) slots[i] <= '0;
      rr_ptr <= '0;
    end else if (inv) begin
      for (int i = 0; i < SLOTS; i++) slots[i].valid <= 1'b0;
      rr_ptr <= '0;
    end else if (wr_en) begin
      slots[victim] <= '{valid: 1'b1, tag: wr_vpn, frame: wr_frame};
      if (full) rr_ptr <= step_ptr(rr_ptr);
    end
  end
endmodule

// File: rtl/walk_arbiter.sv
module walk_arbiter
  import split_xlat_pkg::*;
(
  input  logic             i_need,
  input  logic [VPN_W-1:0] i_vpn,
  input  logic             d_need,
  input  logic [VPN_W-1:0] d_vpn,
  output logic             req,
  output logic             side,
  output logic [VPN_W-1:0] vpn
);
  always_comb begin
    req  = i_need || d_need;
    side = SIDE_INSTR;
    vpn  = '0;
    if (i_need) begin
      side = SIDE_INSTR;
      vpn  = i_vpn;
    end else if (d_need) begin
      side = SIDE_DATA;
      vpn  = d_vpn;
    end
  end
endmodule

// File: rtl/split_xlat_buffer.sv
module split_xlat_buffer
  import split_xlat_pkg::*;
#(
  parameter int SLOTS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inv_all,
  input  logic             if_req,
  input  logic [VA_W-1:0]  if_vaddr,
  output logic             if_hit,
  output logic [VA_W-1:0]  if_paddr,
  output logic             if_stall,
  input  logic             dt_req,
  input  logic [VA_W-1:0]  dt_vaddr,
  output logic             dt_hit,
  output logic [VA_W-1:0]  dt_paddr,
  output logic             dt_stall,
  output logic             walk_req,
  output logic             walk_side,
  output logic [VPN_W-1:0] walk_vpn,
  input  logic             fill_valid,
  input  logic             fill_side,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [VPN_W-1:0] fill_pfn
);
  logic [SLOTS-1:0] i_match_vec, d_match_vec;
  logic [VPN_W-1:0] i_frame, d_frame;
  logic             i_wr, d_wr;

  assign i_wr = fill_valid && (fill_side == SIDE_INSTR);
  assign d_wr = fill_valid && (fill_side == SIDE_DATA);

  xlat_half #(.SLOTS(SLOTS)) u_ihalf (
    .clk(clk), .rst_n(rst_n), .inv(inv_all),
    .vpn_in(if_vaddr[VA_W-1:OFF_W]), .hit(if_hit), .frame_out(i_frame),
    .match_vec(i_match_vec), .wr_en(i_wr), .wr_vpn(fill_vpn), .wr_frame(fill_pfn));

  xlat_half #(.SLOTS(SLOTS)) u_dhalf (
    .clk(clk), .rst_n(rst_n), .inv(inv_all),
    .vpn_in(dt_vaddr[VA_W-1:OFF_W]), .hit(dt_hit), .frame_out(d_frame),
    .match_vec(d_match_vec), .wr_en(d_wr), .wr_vpn(fill_vpn), .wr_frame(fill_pfn));

  assign if_paddr = join_addr(if_hit, i_frame, if_vaddr);
  assign dt_paddr = join_addr(dt_hit, d_frame, dt_vaddr);
  assign if_stall = if_req && !if_hit;
  assign dt_stall = dt_req && !dt_hit;

  walk_arbiter u_arb (
    .i_need(if_stall), .i_vpn(if_vaddr[VA_W-1:OFF_W]),
    .d_need(dt_stall), .d_vpn(dt_vaddr[VA_W-1:OFF_W]),
    .req(walk_req), .side(walk_side), .vpn(walk_vpn));
endmodule

// File: rtl/split_xlat_checker.sv
module split_xlat_checker #(
  parameter int SLOTS = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             inv_all,
  input logic             if_req,
  input logic [31:0]      if_vaddr,
  input logic             if_hit,
  input logic [31:0]      if_paddr,
  input logic             if_stall,
  input logic             dt_req,
  input logic [31:0]      dt_vaddr,
  input logic             dt_hit,
  input logic [31:0]      dt_paddr,
  input logic             dt_stall,
  input logic             walk_req,
  input logic             walk_side,
  input logic [19:0]      walk_vpn,
  input logic [SLOTS-1:0] i_match_vec,
  input logic [SLOTS-1:0] d_match_vec
);
  p_offset_i_r2: assert property (@(posedge clk) disable iff (!rst_n)
    if_hit |-> if_paddr[11:0] == if_vaddr[11:0]);
  p_offset_d_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dt_hit |-> dt_paddr[11:0] == dt_vaddr[11:0]);
  p_single_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(i_match_vec) && $onehot0(d_match_vec));
  p_walk_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    walk_req |-> (if_stall || dt_stall));
  p_idle_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!if_req && !dt_req) |-> !walk_req && !if_stall && !dt_stall);
  p_instr_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (if_stall && dt_stall) |-> walk_req && !walk_side && walk_vpn == if_vaddr[31:12]);
  p_inv_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |=> (i_match_vec == '0) && (d_match_vec == '0));
endmodule

bind split_xlat_buffer split_xlat_checker #(.SLOTS(SLOTS)) u_chk (
  .clk(clk), .rst_n(rst_n), .inv_all(inv_all),
  .if_req(if_req), .if_vaddr(if_vaddr), .if_hit(if_hit), .if_paddr(if_paddr),
  .if_stall(if_stall), .dt_req(dt_req), .dt_vaddr(dt_vaddr), .dt_hit(dt_hit),
  .dt_paddr(dt_paddr), .dt_stall(dt_stall), .walk_req(walk_req),
  .walk_side(walk_side), .walk_vpn(walk_vpn),
  .i_match_vec(i_match_vec), .d_match_vec(d_match_vec));

// File: tb/split_xlat_buffer_test.sv
module split_xlat_buffer_test;
  logic clk = 1'b0, rst_n = 1'b0, inv_all = 1'b0;
  logic if_req = 1'b0, dt_req = 1'b0;
  logic [31:0] if_vaddr = '0, dt_vaddr = '0;
  logic if_hit, dt_hit, if_stall, dt_stall, walk_req, walk_side;
  logic [31:0] if_paddr, dt_paddr;
  logic [19:0] walk_vpn;
  logic fill_valid = 1'b0, fill_side = 1'b0;
  logic [19:0] fill_vpn = '0, fill_pfn = '0;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  split_xlat_buffer uut (.*);

  // {side, vaddr, expected hit, expected paddr}
  localparam logic [65:0] VEC [8] = '{
    {1'b0, 32'h0000_1234, 1'b1, 32'h8000_1234},
    {1'b0, 32'h1234_5FFF, 1'b1, 32'hABCD_EFFF},
    {1'b1, 32'h0000_1000, 1'b1, 32'h4000_1000},
    {1'b1, 32'h1234_5678, 1'b0, 32'h0000_0000},
    {1'b0, 32'h0000_2000, 1'b0, 32'h0000_0000},
    {1'b1, 32'h0000_1ABC, 1'b1, 32'h4000_1ABC},
    {1'b0, 32'h1234_5000, 1'b1, 32'hABCD_E000},
    {1'b0, 32'hFFFF_F123, 1'b0, 32'h0000_0000}
  };

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic fill(input logic side, input logic [19:0] vpn, input logic [19:0] pfn);
    @(negedge clk);
    fill_valid = 1'b1; fill_side = side; fill_vpn = vpn; fill_pfn = pfn;
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic look(input logic side, input logic [31:0] va, input logic eh,
                      input logic [31:0] ep, input string tag);
    @(negedge clk);
    if (side) begin dt_req = 1'b1; dt_vaddr = va; end
    else begin if_req = 1'b1; if_vaddr = va; end
    #2;
    if (side) begin
      check(dt_hit == eh && dt_paddr == ep, tag, {dt_hit, dt_paddr}, {eh, ep});
      check(dt_stall == !eh && walk_req == !eh, tag, {dt_stall, walk_req}, {!eh, !eh});
    end else begin
      check(if_hit == eh && if_paddr == ep, tag, {if_hit, if_paddr}, {eh, ep});
      check(if_stall == !eh && walk_req == !eh, tag, {if_stall, walk_req}, {!eh, !eh});
    end
    if (!eh) check(walk_side == side && walk_vpn == va[31:12], {tag, " R4 walk"},
                   {walk_side, walk_vpn}, {side, va[31:12]});
    if_req = 1'b0; dt_req = 1'b0;
  endtask

  task automatic invalidate(input logic with_fill, input logic [19:0] vpn);
    @(negedge clk);
    inv_all = 1'b1;
    fill_valid = with_fill; fill_side = 1'b1; fill_vpn = vpn; fill_pfn = 20'h77777;
    @(negedge clk);
    inv_all = 1'b0; fill_valid = 1'b0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: empty after reset
    look(1'b0, 32'h0000_1234, 1'b0, 32'h0, "R1 instr empty");
    look(1'b1, 32'h0000_1000, 1'b0, 32'h0, "R1 data empty");
    // R5: no request, no stall or walk
    @(negedge clk); if_vaddr = 32'hDEAD_0000; dt_vaddr = 32'hBEEF_0000; #2;
    check(!walk_req && !if_stall && !dt_stall && !if_hit, "R5 idle", {walk_req, if_stall, dt_stall}, 0);
    // R6: both miss, instruction first
    @(negedge clk); if_req = 1'b1; dt_req = 1'b1;
    if_vaddr = 32'h0000_1234; dt_vaddr = 32'h0000_1000; #2;
    check(walk_req && walk_side == 1'b0 && walk_vpn == 20'h00001, "R6 instr first",
          {walk_req, walk_side, walk_vpn}, {1'b1, 1'b0, 20'h00001});
    fill(1'b0, 20'h00001, 20'h80001);
    if_req = 1'b1; dt_req = 1'b1; #2;
    check(if_hit && walk_side == 1'b1 && walk_vpn == 20'h00001 && dt_stall, "R6 data next",
          {if_hit, walk_side, dt_stall}, {1'b1, 1'b1, 1'b1});
    if_req = 1'b0; dt_req = 1'b0;
    // R3: instruction mapping absent from data half until filled
    look(1'b1, 32'h0000_1000, 1'b0, 32'h0, "R3 data separate");
    fill(1'b1, 20'h00001, 20'h40001);
    fill(1'b0, 20'h12345, 20'hABCDE);
    // R2 R3 R4 table
    foreach (VEC[k]) begin
      look(VEC[k][65], VEC[k][64:33], VEC[k][32], VEC[k][31:0], $sformatf("R2 vec %0d", k));
    end
    // R3: both halves translate in one cycle
    @(negedge clk); if_req = 1'b1; dt_req = 1'b1;
    if_vaddr = 32'h1234_5ABC; dt_vaddr = 32'h0000_1FFF; #2;
    check(if_paddr == 32'hABCD_EABC && dt_paddr == 32'h4000_1FFF && !walk_req, "R3 dual",
          {if_paddr, dt_paddr}, {32'hABCD_EABC, 32'h4000_1FFF});
    if_req = 1'b0; dt_req = 1'b0;
    // R9: invalidate clears both
    invalidate(1'b0, 20'h0);
    look(1'b0, 32'h1234_5000, 1'b0, 32'h0, "R9 instr cleared");
    look(1'b1, 32'h0000_1000, 1'b0, 32'h0, "R9 data cleared");
    // R7: sixteen mappings kept
    for (int i = 0; i < 16; i++) fill(1'b1, 20'h00100 + 20'(i), 20'h00200 + 20'(i));
    for (int i = 0; i < 16; i++)
      look(1'b1, {20'h00100 + 20'(i), 12'h055}, 1'b1, {20'h00200 + 20'(i), 12'h055}, "R7 full");
    // R8: round-robin eviction
    fill(1'b1, 20'h00300, 20'h00333);
    look(1'b1, 32'h0010_0000, 1'b0, 32'h0, "R8 slot0 evicted");
    look(1'b1, 32'h0010_1000, 1'b1, 32'h0020_1000, "R8 slot1 kept");
    look(1'b1, 32'h0030_0010, 1'b1, 32'h0033_3010, "R8 new mapping");
    fill(1'b1, 20'h00301, 20'h00334);
    look(1'b1, 32'h0010_1000, 1'b0, 32'h0, "R8 slot1 evicted");
    look(1'b1, 32'h0010_2000, 1'b1, 32'h0020_2000, "R8 slot2 kept");
    // R9: fill dropped during invalidate, pointer back to 0
    invalidate(1'b1, 20'h00400);
    look(1'b1, 32'h0040_0000, 1'b0, 32'h0, "R9 fill dropped");
    look(1'b1, 32'h0030_0000, 1'b0, 32'h0, "R9 data cleared again");
    for (int i = 0; i < 16; i++) fill(1'b1, 20'h00500 + 20'(i), 20'h00600 + 20'(i));
    fill(1'b1, 20'h00700, 20'h00701);
    look(1'b1, 32'h0050_0000, 1'b0, 32'h0, "R9 pointer reset evicts slot0");
    look(1'b1, 32'h0050_2000, 1'b1, 32'h0060_2000, "R9 slot2 kept");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule